// File: doc/BRIEF.md
# Writeback/Writethrough Line State Controller

This controller assigns the coherence state of each data cache line. A cacheable read miss fills a line, and a write hit to a shared line can promote it. In both cases the controller reads an external policy pin together with the page-level writethrough attribute. It watches the active-low burst-ready and next-address strobes of the bus cycle it starts. It captures the policy pin once, on the first edge where either strobe is low, and holds that value until the cycle ends. It keeps a small array with one state per line: invalid, shared, exclusive or modified.

A caller issues one request at a time while `busy` is low. A request carries an operation, a line index, a cacheable flag and the page writethrough bit. Write hits to exclusive or modified lines complete locally. Writes to shared lines, and write misses, go out on the bus. Snoop and flush requests to a modified line start a writeback burst with `wb_req` raised, and the line ends invalid. Every request ends with a one-cycle `upd_vld` pulse that reports the line and its resulting state. The `look_idx`/`look_state` port gives the tag-compare logic a combinational view of any line's state.

Top module: `wbwt_line_ctrl`

## Requirements
- R1: After reset every line reads invalid (code 2'b00) on `look_state`, and `busy`, `bus_req`, `wb_req` and `upd_vld` are low.
- R2: In an eligible cycle the policy pin is captured on the first clock edge where `brdy_n` or `na_n` is low. Its value on every later edge of that cycle, including the remaining beats of a burst, has no effect on the resulting state.
- R3: Only read (op 3'd0) and write (op 3'd1) bus cycles sample the policy pin. A writeback burst and an other-cycle request (op 3'd4 to 3'd7, a single non-write beat) never sample it, and the other-cycle request leaves the line state unchanged.
- R4: A cacheable read miss, or a write to a shared (2'b01) line, leaves the line shared when the captured pin is low or `req_pwt` is high.
- R5: The same events leave the line exclusive (2'b10) when the captured pin is high and `req_pwt` is low.
- R6: A write to a shared or invalid line runs a single-beat external write (`bus_req` and `bus_write` high, `bus_burst` low). A write miss allocates nothing and the line stays invalid.
- R7: A write to an exclusive line makes it modified (2'b11) with no bus cycle. `upd_vld` rises one cycle after acceptance.
- R8: A write to a modified line leaves it modified with no bus cycle.
- R9: A snoop (op 3'd2) or flush (op 3'd3) to a modified line raises `wb_req` with a BEATS-beat write burst. The line becomes invalid on the last `brdy_n` beat.
- R10: A snoop or flush to a line that is not modified makes it invalid one cycle after acceptance, with no bus cycle.
- R11: A read hit completes with no bus cycle and no state change. A non-cacheable read runs a single-beat read and leaves the line unchanged.
- R12: Every request ends with exactly one `upd_vld` pulse, while `busy` is low, carrying the request's index and the line's resulting state. A cacheable read miss bursts BEATS beats and ends on the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 3 | 0 read, 1 write, 2 snoop, 3 flush, 4-7 other cycle |
| req_idx | input | IW | Line index |
| req_cacheable | input | 1 | Access may allocate |
| req_pwt | input | 1 | Page writethrough attribute |
| brdy_n | input | 1 | Burst ready, active low |
| na_n | input | 1 | Next address, active low |
| pol_wb | input | 1 | Policy pin: high writeback, low writethrough |
| look_idx | input | IW | Lookup index |
| busy | output | 1 | Request in progress |
| bus_req | output | 1 | Bus cycle active |
| bus_write | output | 1 | Active bus cycle is a write |
| bus_burst | output | 1 | Active bus cycle is a burst |
| wb_req | output | 1 | Writeback of a modified line in progress |
| upd_vld | output | 1 | Request completed |
| upd_idx | output | IW | Index of completed request |
| upd_state | output | 2 | Resulting line state |
| look_state | output | 2 | State of line `look_idx` |

## Verification
Policy capture and cycle completion can fall on the same edge. This happens in a single-beat write to a shared line whose first strobe is `brdy_n` with no earlier `na_n`: the pin value on that edge must reach the new state directly. The bench provokes this with a directed write, then repeats it with `na_n` leading and the pin flipped on the completing beat, and mixes both forms into random traffic with wait states. Each outcome is judged against a bench model that holds only the value driven on the first strobe.

// File: rtl/wbwt_line_ctrl.sv
module wbwt_line_ctrl #(
  parameter int LINES = 16,
  parameter int BEATS = 4,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BW = $clog2(BEATS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [IW-1:0] req_idx,
  input  logic          req_cacheable,
  input  logic          req_pwt,
  input  logic          brdy_n,
  input  logic          na_n,
  input  logic          pol_wb,
  input  logic [IW-1:0] look_idx,
  output logic          busy,
  output logic          bus_req,
  output logic          bus_write,
  output logic          bus_burst,
  output logic          wb_req,
  output logic          upd_vld,
  output logic [IW-1:0] upd_idx,
  output logic [1:0]    upd_state,
  output logic [1:0]    look_state
);

  localparam logic [1:0] S_I = 2'b00, S_S = 2'b01, S_E = 2'b10, S_M = 2'b11;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_SNP = 3'd2, OP_FL = 3'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_BUS, PH_WB} phase_t;

  phase_t        ph;
  logic [1:0]    st [LINES];
  logic [2:0]    op_q;
  logic [IW-1:0] idx_q;
  logic          pwt_q, cache_q, samp_q, cap_q, pol_q, burst_q, wr_q;
  logic [1:0]    cur_q;
  logic [BW-1:0] beat_q;

  wire           accept = (ph == PH_IDLE) && req_valid;
  wire [1:0]     cur    = st[req_idx];
  wire           strobe = !brdy_n || !na_n;
  wire [BW-1:0]  need   = burst_q ? BW'(BEATS) : BW'(1);
  wire           last   = !brdy_n && (beat_q == need - 1'b1);
  wire           pol_e  = cap_q ? pol_q : pol_wb;
  wire [1:0]     fill   = (pol_e && !pwt_q) ? S_E : S_S;
  wire           fills  = ((op_q == OP_RD) && cache_q && (cur_q == S_I)) ||
                          ((op_q == OP_WR) && (cur_q == S_S));
  wire [1:0]     bus_res = fills ? fill : cur_q;

  assign busy       = (ph != PH_IDLE);
  assign bus_req    = (ph != PH_IDLE);
  assign bus_write  = (ph == PH_WB) || ((ph == PH_BUS) && wr_q);
  assign bus_burst  = (ph == PH_WB) || ((ph == PH_BUS) && burst_q);
  assign wb_req     = (ph == PH_WB);
  assign look_state = st[look_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      op_q      <= OP_RD;
      idx_q     <= '0;
      pwt_q     <= 1'b0;
      cache_q   <= 1'b0;
      samp_q    <= 1'b0;
      cap_q     <= 1'b0;
      pol_q     <= 1'b0;
      burst_q   <= 1'b0;
      wr_q      <= 1'b0;
      cur_q     <= S_I;
      beat_q    <= '0;
      upd_vld   <= 1'b0;
      upd_idx   <= '0;
      upd_state <= S_I;
      for (int i = 0; i < LINES; i++) st[i] <= S_I;
    end else begin
      upd_vld <= 1'b0;
      case (ph)
        PH_IDLE: if (accept) begin
          op_q    <= req_op;
          idx_q   <= req_idx;
          pwt_q   <= req_pwt;
          cache_q <= req_cacheable;
          cur_q   <= cur;
          cap_q   <= 1'b0;
          beat_q  <= '0;
          samp_q  <= 1'b0;
          burst_q <= 1'b0;
          wr_q    <= 1'b0;
          upd_idx <= req_idx;
          case (req_op)
            OP_RD: begin
              if (cur != S_I) begin
                upd_vld   <= 1'b1;
                upd_state <= cur;
              end else begin
                ph      <= PH_BUS;
                samp_q  <= 1'b1;
                burst_q <= req_cacheable;
              end
            end
            OP_WR: begin
              if (cur == S_E || cur == S_M) begin
                st[req_idx] <= S_M;
                upd_vld     <= 1'b1;
                upd_state   <= S_M;
              end else begin
                ph     <= PH_BUS;
                samp_q <= 1'b1;
                wr_q   <= 1'b1;
              end
            end
            OP_SNP, OP_FL: begin
              if (cur == S_M) begin
                ph <= PH_WB;
              end else begin
                st[req_idx] <= S_I;
                upd_vld     <= 1'b1;
                upd_state   <= S_I;
              end
            end
            default: ph <= PH_BUS;
          endcase
        end
        PH_BUS: begin
          if (samp_q && !cap_q && strobe) begin
            cap_q <= 1'b1;
            pol_q <= pol_wb;
          end
          if (!brdy_n) beat_q <= beat_q + 1'b1;
          if (last) begin
            ph         <= PH_IDLE;
            st[idx_q]  <= bus_res;
            upd_vld    <= 1'b1;
            upd_state  <= bus_res;
          end
        end
        PH_WB: begin
          if (!brdy_n) beat_q <= beat_q + 1'b1;
          if (!brdy_n && (beat_q == BW'(BEATS - 1))) begin
            ph        <= PH_IDLE;
            st[idx_q] <= S_I;
            upd_vld   <= 1'b1;
            upd_state <= S_I;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !upd_vld && !wb_req); // R1
  AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_BUS && cap_q && $past(ph == PH_BUS && cap_q)) |-> $stable(pol_q)); // R2
  AST_NO_SAMPLE_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WB) |-> !cap_q); // R3
  AST_SHARED_WRITE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == OP_WR && cur == S_S) |=> bus_req && bus_write && !bus_burst); // R6
  AST_EXCL_TO_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == OP_WR && cur == S_E) |=> upd_vld && upd_state == S_M && !bus_req); // R7
  AST_MOD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == OP_WR && cur == S_M) |=> upd_vld && upd_state == S_M && !bus_req); // R8
  AST_MOD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op == OP_SNP || req_op == OP_FL) && cur == S_M) |=> wb_req && bus_burst && bus_write); // R9
  AST_CLEAN_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op == OP_SNP || req_op == OP_FL) && cur != S_M) |=> upd_vld && upd_state == S_I && !bus_req); // R10
  AST_UPD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |-> !busy); // R12

endmodule

// File: tb/wbwt_line_ctrl_test.sv
`timescale 1ns/1ps
module wbwt_line_ctrl_test;
  localparam int LINES = 16;
  localparam int BEATS = 4;
  localparam int IW = $clog2(LINES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_cacheable = 1'b0, req_pwt = 1'b0;
  logic [2:0] req_op = '0;
  logic [IW-1:0] req_idx = '0, look_idx = '0;
  logic brdy_n = 1'b1, na_n = 1'b1, pol_wb = 1'b0;
  logic busy, bus_req, bus_write, bus_burst, wb_req, upd_vld;
  logic [IW-1:0] upd_idx;
  logic [1:0] upd_state, look_state;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [1:0] model [LINES];

  always #4 clk = ~clk;

  wbwt_line_ctrl #(.LINES(LINES), .BEATS(BEATS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
    .req_cacheable(req_cacheable), .req_pwt(req_pwt), .brdy_n(brdy_n), .na_n(na_n),
    .pol_wb(pol_wb), .look_idx(look_idx), .busy(busy), .bus_req(bus_req),
    .bus_write(bus_write), .bus_burst(bus_burst), .wb_req(wb_req), .upd_vld(upd_vld),
    .upd_idx(upd_idx), .upd_state(upd_state), .look_state(look_state));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int beats_for(input logic [2:0] op, input logic [1:0] cur, input logic c);
    if (op == 3'd0) return (cur != 2'b00) ? 0 : (c ? BEATS : 1);
    if (op == 3'd1) return (cur == 2'b10 || cur == 2'b11) ? 0 : 1;
    if (op == 3'd2 || op == 3'd3) return (cur == 2'b11) ? BEATS : 0;
    return 1;
  endfunction

  function automatic logic [1:0] next_for(input logic [2:0] op, input logic [1:0] cur,
                                          input logic c, input logic pwt, input logic pol);
    logic [1:0] f;
    f = (pol && !pwt) ? 2'b10 : 2'b01;
    if (op == 3'd0) return (cur == 2'b00 && c) ? f : cur;
    if (op == 3'd1) return (cur == 2'b01) ? f : ((cur == 2'b00) ? 2'b00 : 2'b11);
    if (op == 3'd2 || op == 3'd3) return 2'b00;
    return cur;
  endfunction

  task automatic do_req(input string tag, input logic [2:0] op, input int idx, input logic c,
                        input logic pwt, input logic pol_first, input logic pol_later,
                        input bit use_na, input int waits);
    logic [1:0] cur, exp;
    int nb;
    bit wb;
    cur = model[idx];
    nb  = beats_for(op, cur, c);
    wb  = (op == 3'd2 || op == 3'd3) && cur == 2'b11;
    exp = next_for(op, cur, c, pwt, pol_first);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_idx = IW'(idx); req_cacheable = c; req_pwt = pwt;
    look_idx = IW'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    if (nb != 0) begin
      check({tag, " bus_req"}, int'(bus_req), 1);
      check({tag, " bus_write"}, int'(bus_write), int'(op == 3'd1 || wb));
      check({tag, " bus_burst"}, int'(bus_burst), int'(nb > 1));
      check({tag, " wb_req"}, int'(wb_req), int'(wb));
      for (int w = 0; w < waits; w++) begin
        brdy_n = 1'b1; na_n = 1'b1; pol_wb = 1'($urandom);
        @(negedge clk);
      end
      if (use_na) begin
        na_n = 1'b0; pol_wb = pol_first;
        @(negedge clk);
        na_n = 1'b1;
      end
      for (int b = 0; b < nb; b++) begin
        brdy_n = 1'b0;
        pol_wb = (b == 0 && !use_na) ? pol_first : pol_later;
        @(negedge clk);
      end
      brdy_n = 1'b1;
    end else begin
      check({tag, " no bus"}, int'(bus_req), 0);
    end
    check({tag, " upd_vld"}, int'(upd_vld), 1);
    check({tag, " upd_idx"}, int'(upd_idx), idx);
    check({tag, " upd_state"}, int'(upd_state), int'(exp));
    check({tag, " busy"}, int'(busy), 0);
    check({tag, " look_state"}, int'(look_state), int'(exp));
    model[idx] = exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) model[i] = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 bus_req", int'(bus_req), 0);
    check("R1 wb_req", int'(wb_req), 0);
    check("R1 upd_vld", int'(upd_vld), 0);
    for (int i = 0; i < LINES; i++) begin
      look_idx = IW'(i);
      #1 check("R1 line invalid", int'(look_state), 0);
    end
    // R5 R2 R12: cacheable read miss, pin high on first beat, low afterwards
    do_req("R5 R2 R12 fill exclusive", 3'd0, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2);
    // R4: writethrough page attribute forces shared
    do_req("R4 pwt shared", 3'd0, 4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    // R4 R2: captured on next-address strobe, pin flips during burst
    do_req("R4 R2 na capture", 3'd0, 5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    // R6 R5: write to shared line, capture and completion on one edge
    do_req("R6 R5 shared write", 3'd1, 5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    // R7
    do_req("R7 excl to mod", 3'd1, 5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    // R8
    do_req("R8 mod stays", 3'd1, 5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    // R9 R3: writeback burst ignores pin
    do_req("R9 R3 snoop writeback", 3'd2, 5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1);
    // R10
    do_req("R10 flush clean", 3'd3, 3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    // R3: other cycle with strobe and pin high leaves shared line alone
    do_req("R3 other cycle", 3'd4, 4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 0);
    // R11
    do_req("R11 noncacheable read", 3'd0, 6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    do_req("R11 read hit", 3'd0, 4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    // R6: write miss no allocate
    do_req("R6 write miss", 3'd1, 7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    // R2 R6: next-address leads, pin flipped on completing beat
    do_req("R2 fill for na write", 3'd0, 8, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    do_req("R2 R6 na write", 3'd1, 8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    // Random traffic, R12
    for (int k = 0; k < 400; k++) begin
      int o;
      logic pf;
      o  = int'($urandom_range(0, 6));
      pf = 1'($urandom);
      do_req("R12 random", (o >= 5) ? 3'd0 : 3'(o), int'($urandom_range(0, LINES - 1)),
             1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0), pf, ~pf,
             1'($urandom), int'($urandom_range(0, 2)));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule